// File: doc/BRIEF.md
# Lamp fault supervisor

This block watches over a multi-lamp inverter and decides when to stop driving it. It takes digitized comparator flags from the lamp current and lamp voltage sense paths, from the compensation node and from a temperature sensor. It also takes strobes for each rectified sense pulse and the burst-dimming ramp. From these it tracks whether the lamps are still being ignited (striking) or are running normally. It runs delay timers and pulse counters against each fault, and latches a shutdown when any of them trips.

Delays are counted in ticks of a shared prescaler. By default one tick is 1 ms of system clock, and the short, mid and long delays are 1, 10 and 1600 ticks. Faults fall into three kinds. Timed faults must persist for their whole window. Counted faults must accumulate rectified pulses between burst-ramp rising edges. Immediate faults trip on the next edge. Every fault except the immediate ones and the striking timeout is ignored while striking. A cause code records the fault that tripped the latch.

Top module: `lamp_fault_supervisor`

## Requirements
- R1: Out of reset, or while `enable` is low or `uvlo` is high, `drive_en`, `striking` and `shutdown` are 0 and `fault_cause` is 0. Once `enable` is high and `uvlo` is low, the block enters striking mode (`drive_en`=1, `striking`=1).
- R2: Striking ends and normal mode begins (`striking`=0, `drive_en`=1) once `cur_min_lt_strike` is low. If striking lasts LONG_TICKS ticks, the block shuts down with cause 3.
- R3: In normal mode, `cur_min_lt_open` held high for MID_TICKS consecutive ticks shuts down with cause 4. Any low cycle restarts the window.
- R4: In normal mode, `vol_pulse` strobes seen while `vol_max_gt_reg` is high are counted. Reaching REG_PULSES shuts down with cause 7. Strobes seen while the flag is low are not counted.
- R5: A rising edge of `burst_ramp` clears both pulse counters, so a full new count is needed after it.
- R6: `vol_max_gt_arc` high in striking or normal mode sets `shutdown` at the next clock edge with cause 2.
- R7: In normal mode, `vol_min_lt_short` held high for SHORT_TICKS ticks shuts down with cause 5. The flag has no effect while striking.
- R8: In normal mode, `comp_gt_high` held high for MID_TICKS ticks shuts down with cause 6. The flag has no effect while striking.
- R9: In normal mode, `cur_pulse` strobes seen while `cur_max_gt_high` is high are counted. Reaching FB_PULSES shuts down with cause 8. Neither counter advances while striking.
- R10: `over_temp` high in striking or normal mode sets `shutdown` at the next clock edge with cause 1.
- R11: Once set, `shutdown` stays 1 and `drive_en` stays 0 whatever the fault flags do. Both stay that way until `enable` goes low or `uvlo` goes high, which clears `shutdown` and `fault_cause` at the next edge.
- R12: If several faults trip in the same cycle, the lowest cause code is kept. A later fault never overwrites the recorded cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Turn-on request |
| uvlo | input | 1 | Supply undervoltage lockout |
| cur_min_lt_strike | input | 1 | Minimum lamp-current feedback below the ignition level |
| cur_min_lt_open | input | 1 | Minimum lamp-current feedback below the open-lamp level |
| cur_max_gt_high | input | 1 | Maximum lamp-current feedback above the high level |
| vol_max_gt_reg | input | 1 | Maximum lamp-voltage feedback above the regulation level |
| vol_max_gt_arc | input | 1 | Maximum lamp-voltage feedback above the arc level |
| vol_min_lt_short | input | 1 | Minimum lamp-voltage feedback below the short-lamp level |
| comp_gt_high | input | 1 | Compensation node above its high limit |
| over_temp | input | 1 | Over-temperature flag |
| cur_pulse | input | 1 | One-cycle strobe per rectified current-sense pulse |
| vol_pulse | input | 1 | One-cycle strobe per rectified voltage-sense pulse |
| burst_ramp | input | 1 | Burst-dimming ramp phase; rising edge clears counters |
| drive_en | output | 1 | Bridge drive permitted (striking or normal) |
| striking | output | 1 | Ignition mode |
| shutdown | output | 1 | Latched fault shutdown |
| fault_cause | output | 4 | Cause code of the fault that tripped the latch, 0 when none |

## Verification
The assertions assume that every flag is already synchronous to `clk` and that each pulse strobe lasts one cycle. They also assume that `burst_ramp` is a level whose rising edge the block detects itself. The bench drives every input on the falling edge and holds each strobe for one cycle with a low cycle between strobes. Timed windows are checked against bounds one tick wide, because the prescaler phase is free-running. The sample points are placed safely inside those bounds.

// File: rtl/lamp_fault_supervisor.sv
module lamp_fault_supervisor #(
  parameter int CLKS_PER_TICK = 50000,
  parameter int SHORT_TICKS   = 1,
  parameter int MID_TICKS     = 10,
  parameter int LONG_TICKS    = 1600,
  parameter int REG_PULSES    = 32,
  parameter int FB_PULSES     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       uvlo,
  input  logic       cur_min_lt_strike,
  input  logic       cur_min_lt_open,
  input  logic       cur_max_gt_high,
  input  logic       vol_max_gt_reg,
  input  logic       vol_max_gt_arc,
  input  logic       vol_min_lt_short,
  input  logic       comp_gt_high,
  input  logic       over_temp,
  input  logic       cur_pulse,
  input  logic       vol_pulse,
  input  logic       burst_ramp,
  output logic       drive_en,
  output logic       striking,
  output logic       shutdown,
  output logic [3:0] fault_cause
);
  localparam int PW = $clog2(CLKS_PER_TICK);
  localparam int TW = $clog2(LONG_TICKS + 1);
  localparam int RW = $clog2(REG_PULSES + 1);
  localparam int FW = $clog2(FB_PULSES + 1);

  localparam logic [3:0] C_NONE   = 4'd0;
  localparam logic [3:0] C_TEMP   = 4'd1;
  localparam logic [3:0] C_ARC    = 4'd2;
  localparam logic [3:0] C_STRIKE = 4'd3;
  localparam logic [3:0] C_OPEN   = 4'd4;
  localparam logic [3:0] C_SHORT  = 4'd5;
  localparam logic [3:0] C_COMP   = 4'd6;
  localparam logic [3:0] C_VCNT   = 4'd7;
  localparam logic [3:0] C_ICNT   = 4'd8;

  typedef enum logic [1:0] {S_IDLE, S_STRIKE, S_NORMAL, S_TRIP} state_t;

  state_t         state;
  logic [3:0]     cause, nxt_cause;
  logic [PW-1:0]  pre;
  logic           tick, burst_q, burst_edge;
  logic [RW-1:0]  vcnt;
  logic [FW-1:0]  icnt;
  logic [3:0]     t_cond, t_done;

  wire active    = enable & ~uvlo;
  wire in_strike = (state == S_STRIKE);
  wire in_normal = (state == S_NORMAL);
  wire live      = in_strike | in_normal;

  assign tick       = live && (pre == PW'(CLKS_PER_TICK - 1));
  assign burst_edge = burst_ramp & ~burst_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pre <= '0;
    else if (!live || tick)    pre <= '0;
    else                       pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) burst_q <= 1'b0;
    else        burst_q <= burst_ramp;

  assign t_cond = {in_normal & comp_gt_high,
                   in_normal & vol_min_lt_short,
                   in_normal & cur_min_lt_open,
                   in_strike};

  for (genvar i = 0; i < 4; i++) begin : g_tmr
    localparam int LIM = (i == 0) ? LONG_TICKS :
                         (i == 2) ? SHORT_TICKS : MID_TICKS;
    logic [TW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           cnt <= '0;
      else if (!t_cond[i])                  cnt <= '0;
      else if (tick && cnt != TW'(LIM))     cnt <= cnt + 1'b1;
    assign t_done[i] = t_cond[i] && (cnt == TW'(LIM));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                vcnt <= '0;
    else if (!in_normal || burst_edge)         vcnt <= '0;
    else if (vol_pulse && vol_max_gt_reg && vcnt != RW'(REG_PULSES))
                                               vcnt <= vcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                icnt <= '0;
    else if (!in_normal || burst_edge)         icnt <= '0;
    else if (cur_pulse && cur_max_gt_high && icnt != FW'(FB_PULSES))
                                               icnt <= icnt + 1'b1;

  wire vcnt_done = in_normal && (vcnt == RW'(REG_PULSES));
  wire icnt_done = in_normal && (icnt == FW'(FB_PULSES));

  always_comb begin
    if      (over_temp)      nxt_cause = C_TEMP;
    else if (vol_max_gt_arc) nxt_cause = C_ARC;
    else if (t_done[0])      nxt_cause = C_STRIKE;
    else if (t_done[1])      nxt_cause = C_OPEN;
    else if (t_done[2])      nxt_cause = C_SHORT;
    else if (t_done[3])      nxt_cause = C_COMP;
    else if (vcnt_done)      nxt_cause = C_VCNT;
    else if (icnt_done)      nxt_cause = C_ICNT;
    else                     nxt_cause = C_NONE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      cause <= C_NONE;
    end else if (!active) begin
      state <= S_IDLE;
      cause <= C_NONE;
    end else begin
      case (state)
        S_IDLE:   state <= S_STRIKE;
        S_STRIKE, S_NORMAL:
          if (nxt_cause != C_NONE) begin
            state <= S_TRIP;
            cause <= nxt_cause;
          end else if (in_strike && !cur_min_lt_strike) begin
            state <= S_NORMAL;
          end
        default:  state <= S_TRIP;
      endcase
    end

  assign drive_en    = live;
  assign striking    = in_strike;
  assign shutdown    = (state == S_TRIP);
  assign fault_cause = cause;

  assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && enable && !uvlo) |=> (shutdown && !drive_en))
    else $error("latch released while enabled");

  assert_latch_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || uvlo) |=> (!shutdown && fault_cause == 4'd0 && !drive_en))
    else $error("latch not cleared");

  assert_arc_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && vol_max_gt_arc && enable && !uvlo) |=> shutdown)
    else $error("arc did not trip");

  assert_temp_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && over_temp && enable && !uvlo) |=> (shutdown && fault_cause == 4'd1))
    else $error("over-temperature did not trip");

  assert_cause_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && enable && !uvlo) |=> $stable(fault_cause))
    else $error("cause overwritten");

  assert_strike_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(shutdown) && $past(striking)) |-> (fault_cause >= 4'd1 && fault_cause <= 4'd3))
    else $error("normal-only fault tripped while striking");

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt <= RW'(REG_PULSES)) && (icnt <= FW'(FB_PULSES)))
    else $error("pulse counter overran");
endmodule

// File: tb/test_lamp_fault_supervisor.sv
module test_lamp_fault_supervisor;
  localparam int P = 4, SH = 2, MD = 5, LG = 12, RP = 32, FP = 8;

  logic clk = 0, rst_n = 0;
  logic enable = 0, uvlo = 0;
  logic cur_min_lt_strike = 0, cur_min_lt_open = 0, cur_max_gt_high = 0;
  logic vol_max_gt_reg = 0, vol_max_gt_arc = 0, vol_min_lt_short = 0;
  logic comp_gt_high = 0, over_temp = 0, cur_pulse = 0, vol_pulse = 0, burst_ramp = 0;
  logic drive_en, striking, shutdown;
  logic [3:0] fault_cause;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lamp_fault_supervisor #(.CLKS_PER_TICK(P), .SHORT_TICKS(SH), .MID_TICKS(MD),
    .LONG_TICKS(LG), .REG_PULSES(RP), .FB_PULSES(FP)) i_lamp_fault_supervisor (.*);

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    cur_min_lt_open = 0; cur_max_gt_high = 0; vol_max_gt_reg = 0;
    vol_max_gt_arc = 0; vol_min_lt_short = 0; comp_gt_high = 0; over_temp = 0;
    cur_pulse = 0; vol_pulse = 0; burst_ramp = 0;
  endtask

  task automatic restart();
    enable = 0; uvlo = 0; clear_flags(); cur_min_lt_strike = 1;
    wait_n(2);
    enable = 1;
    wait_n(2);
  endtask

  task automatic to_normal();
    cur_min_lt_strike = 0;
    wait_n(2);
  endtask

  task automatic vpulses(input int n);
    for (int k = 0; k < n; k++) begin
      vol_pulse = 1; wait_n(1); vol_pulse = 0; wait_n(1);
    end
  endtask

  task automatic ipulses(input int n);
    for (int k = 0; k < n; k++) begin
      cur_pulse = 1; wait_n(1); cur_pulse = 0; wait_n(1);
    end
  endtask

  task automatic burst();
    burst_ramp = 1; wait_n(1); burst_ramp = 0; wait_n(1);
  endtask

  task automatic set_flag(input int which, input logic v);
    case (which)
      0: cur_min_lt_open = v;
      1: vol_min_lt_short = v;
      default: comp_gt_high = v;
    endcase
  endtask

  // timed normal-mode fault: window restart on dropout, then full window trips
  task automatic timed_fault(input string req, input int which, input int lim, input int code);
    restart(); to_normal();
    set_flag(which, 1); wait_n((lim - 1) * P - 2);
    set_flag(which, 0); wait_n(1);
    set_flag(which, 1); wait_n((lim - 1) * P - 2);
    check(req, shutdown, 0);
    wait_n(P + 5);
    check(req, shutdown, 1);
    check(req, fault_cause, code);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    // R1 reset and idle state
    check("R1", drive_en, 0); check("R1", shutdown, 0); check("R1", fault_cause, 0);
    restart();
    check("R1", striking, 1); check("R1", drive_en, 1);
    // R2 transition to normal
    to_normal();
    check("R2", striking, 0); check("R2", drive_en, 1); check("R2", shutdown, 0);
    // R2 striking timeout
    restart();
    wait_n((LG - 1) * P - 2);
    check("R2", shutdown, 0);
    wait_n(P + 5);
    check("R2", shutdown, 1); check("R2", fault_cause, 3); check("R2", drive_en, 0);
    // R7 R8 R9 normal-only faults ignored while striking
    restart();
    comp_gt_high = 1; vol_min_lt_short = 1; cur_min_lt_open = 1;
    vol_max_gt_reg = 1; cur_max_gt_high = 1;
    vpulses(10); ipulses(10); wait_n(4);
    check("R7", shutdown, 0); check("R8", striking, 1); check("R9", fault_cause, 0);
    clear_flags(); to_normal();
    vol_max_gt_reg = 1; cur_max_gt_high = 1;
    vpulses(RP - 1); ipulses(FP - 1); wait_n(3);
    check("R9", shutdown, 0);
    // R3 R7 R8 timed faults
    timed_fault("R3", 0, MD, 4);
    timed_fault("R7", 1, SH, 5);
    timed_fault("R8", 2, MD, 6);
    // R4 sweep over pulse counts near the limit
    for (int n = RP - 2; n <= RP + 1; n++) begin
      restart(); to_normal();
      vol_max_gt_reg = 1; vpulses(n); wait_n(3);
      check("R4", shutdown, (n >= RP) ? 1 : 0);
      check("R4", fault_cause, (n >= RP) ? 7 : 0);
    end
    restart(); to_normal();
    vpulses(RP + 4); wait_n(3);
    check("R4", shutdown, 0);
    // R5 burst edge clears the voltage-pulse counter
    restart(); to_normal();
    vol_max_gt_reg = 1; vpulses(RP - 1); burst(); vpulses(RP - 1); wait_n(3);
    check("R5", shutdown, 0);
    vpulses(1); wait_n(3);
    check("R5", shutdown, 1); check("R5", fault_cause, 7);
    // R9 current-pulse counter sweep and R5 clear
    for (int n = FP - 1; n <= FP; n++) begin
      restart(); to_normal();
      cur_max_gt_high = 1; ipulses(n); wait_n(3);
      check("R9", shutdown, (n >= FP) ? 1 : 0);
      check("R9", fault_cause, (n >= FP) ? 8 : 0);
    end
    restart(); to_normal();
    cur_max_gt_high = 1; ipulses(FP - 1); burst(); ipulses(FP - 1); wait_n(3);
    check("R5", shutdown, 0);
    // R6 arc in striking and normal
    restart();
    vol_max_gt_arc = 1; wait_n(1);
    check("R6", shutdown, 1); check("R6", fault_cause, 2);
    restart(); to_normal();
    vol_max_gt_arc = 1; wait_n(1);
    check("R6", shutdown, 1); check("R6", fault_cause, 2);
    // R10 over-temperature
    restart(); to_normal();
    over_temp = 1; wait_n(1);
    check("R10", shutdown, 1); check("R10", fault_cause, 1);
    // R12 priority and first-cause retention
    restart(); to_normal();
    over_temp = 1; vol_max_gt_arc = 1; wait_n(1);
    check("R12", fault_cause, 1);
    restart(); to_normal();
    vol_max_gt_arc = 1; wait_n(1); over_temp = 1; wait_n(3);
    check("R12", fault_cause, 2);
    // R11 latch hold and release by enable
    clear_flags(); wait_n(20);
    check("R11", shutdown, 1); check("R11", drive_en, 0);
    enable = 0; wait_n(1);
    check("R11", shutdown, 0); check("R11", fault_cause, 0);
    cur_min_lt_strike = 1; enable = 1; wait_n(2);
    check("R11", striking, 1);
    // R11 release by undervoltage
    over_temp = 1; wait_n(1); over_temp = 0;
    check("R11", shutdown, 1);
    uvlo = 1; wait_n(1);
    check("R11", shutdown, 0); check("R1", drive_en, 0);
    uvlo = 0; wait_n(2);
    check("R1", striking, 1);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule